// File: doc/BRIEF.md
# Idle Storage Power Manager

This block owns the supply rail and the pad mode of a multi-bank flash storage subsystem. It keeps a count of coarse time ticks since the subsystem was last used. Once that count runs past a limit, it drops the supply on its own. The count is not examined every clock. A periodic check samples it, and one cycle before the rail falls the block raises a notification pulse so that higher layers can flush or record state.

When an access arrives while the supply is off, the block turns the rail on and switches the pads to their flash-interface function. It then waits a fixed settle time and asks each populated bank, and no other, to reset. Only after every requested bank has answered does it grant the access. If any bank reports a failed reset, the block enters a latched fault state that only a system reset clears.

Every interval derives from one prescaled tick. A bench can therefore shrink all periods by changing parameters.

Accesses use a valid/ready handshake. The requester raises `acc_valid` and holds it. A transfer takes place on any rising edge where `acc_valid` and `acc_ready` are both high. `acc_ready` is the only back-pressure, and it stays low while the rail is off, while the power-up sequence runs and while the block is faulted. `acc_done` is a plain one-cycle strobe that marks the end of an access.

Top module: `flash_pwr_mgr`

## Requirements
- R1: After reset, `rail_en`, `pin_func`, `acc_ready`, `idle_pulse` and `fatal` are 0, and `bank_rst_req` is all zero.
- R2: With the rail off, `acc_valid` high makes `rail_en` and `pin_func` (1 = flash function, 0 = plain output-low) rise together on the next edge. `acc_ready` stays 0 until the power-up sequence has completed.
- R3: `bank_rst_req` first becomes non-zero exactly SETTLE_TICKS*TICK_DIV cycles after `rail_en` rises, and it is all zero before then.
- R4: Bit i of `bank_rst_req` is raised only when bit i of `bank_present` is 1 at the end of the settle time. It stays high until `bank_rst_done[i]` or `bank_rst_fail[i]` is seen. Done or fail on a bank that was not requested is ignored.
- R5: When every requested bank has answered done, with no fail, `acc_ready` rises within two cycles of the last answer. With an empty mask, `acc_ready` rises without any reset request.
- R6: If any requested bank answers fail, `fatal` goes high and stays high, with `acc_ready` low, until `rst_n` is asserted.
- R7: The activity count restarts on each handshake (`acc_valid` and `acc_ready` both high), on each `acc_done` strobe and when power-up completes.
- R8: The idle check runs once every CHECK_TICKS ticks. At a check with more than IDLE_TICKS ticks elapsed since the last activity, a powered block shuts down. The rail therefore stays on for more than IDLE_TICKS*TICK_DIV cycles after the last activity, and it falls no later than (IDLE_TICKS+CHECK_TICKS+1)*TICK_DIV+3 cycles after it.
- R9: `idle_pulse` is high for exactly one cycle, the cycle just before `rail_en` and `pin_func` fall. The rail never falls without it.
- R10: While unpowered, idle checks do nothing: no `idle_pulse`, and the rail and pad mode stay off.
- R11: `acc_ready` is high only while the rail is on, the pads are in flash mode and the block is not faulted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access request, held until accepted |
| acc_ready | output | 1 | Access grant; a transfer occurs when both are high |
| acc_done | input | 1 | One-cycle strobe at access completion |
| bank_present | input | NB | Populated-bank mask |
| bank_rst_req | output | NB | Per-bank reset request, held until answered |
| bank_rst_done | input | NB | Per-bank reset success strobe |
| bank_rst_fail | input | NB | Per-bank reset failure strobe |
| rail_en | output | 1 | Supply rail enable |
| pin_func | output | 1 | Pad mode: 1 flash function, 0 output-low |
| idle_pulse | output | 1 | One-cycle notice before shutdown |
| fatal | output | 1 | Latched reset-failure fault |

## Verification
Several properties are checked on every cycle. The rail never falls without a preceding single-cycle notice, and a grant never appears without power. The fault never clears by itself, and each reset request holds until its bank answers. The bench scenarios are what show the exact settle delay, which banks are requested under various masks and failure patterns, and the window in which an idle shutdown lands relative to the last activity. They also show that `acc_done` strobes keep the rail up, and that idle checks stay inert while unpowered.

// File: rtl/pm_pkg.sv
package pm_pkg;
  typedef enum logic [2:0] {
    PM_OFF     = 3'd0,
    PM_SETTLE  = 3'd1,
    PM_BANKRST = 3'd2,
    PM_ON      = 3'd3,
    PM_NOTIFY  = 3'd4,
    PM_FAULT   = 3'd5
  } pm_state_e;
endpackage

// File: rtl/pm_tick_gen.sv
module pm_tick_gen #(
  parameter int TICK_DIV = 100000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/pm_idle_mon.sv
module pm_idle_mon #(
  parameter int CHECK_TICKS = 100,
  parameter int IDLE_TICKS  = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic touch,
  output logic expire
);
  localparam int IW = $clog2(IDLE_TICKS + 2);
  localparam int CW = (CHECK_TICKS > 1) ? $clog2(CHECK_TICKS) : 1;
  localparam logic [IW-1:0] SAT   = IW'(IDLE_TICKS + 1);
  localparam logic [IW-1:0] LIMIT = IW'(IDLE_TICKS);
  localparam logic [CW-1:0] CLAST = CW'(CHECK_TICKS - 1);

  logic [IW-1:0] idle_q;
  logic [CW-1:0] chk_q;
  logic          chk_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    idle_q <= '0;
    else if (touch)                idle_q <= '0;
    else if (tick && idle_q != SAT) idle_q <= idle_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   chk_q <= '0;
    else if (tick) chk_q <= (chk_q == CLAST) ? '0 : chk_q + 1'b1;
  end

  assign chk_hit = tick && (chk_q == CLAST);
  assign expire  = chk_hit && !touch && (idle_q > LIMIT);
endmodule

// File: rtl/pm_bank_rst.sv
module pm_bank_rst #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NB-1:0] present,
  input  logic [NB-1:0] done,
  input  logic [NB-1:0] fail,
  output logic [NB-1:0] req,
  output logic          all_clear,
  output logic          any_fail
);
  logic [NB-1:0] pend_q;
  logic [NB-1:0] fail_q;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[b] <= 1'b0;
        fail_q[b] <= 1'b0;
      end else if (start) begin
        pend_q[b] <= present[b];
        fail_q[b] <= 1'b0;
      end else if (pend_q[b] && (done[b] || fail[b])) begin
        pend_q[b] <= 1'b0;
        fail_q[b] <= fail[b];
      end
    end

    assert_req_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req[b] && !done[b] && !fail[b] && !start) |=> req[b]);
  end

  assign req       = pend_q;
  assign all_clear = ~|pend_q;
  assign any_fail  = |fail_q;
endmodule

// File: rtl/flash_pwr_mgr.sv
module flash_pwr_mgr
  import pm_pkg::*;
#(
  parameter int NB           = 4,
  parameter int TICK_DIV     = 100000,
  parameter int CHECK_TICKS  = 100,
  parameter int IDLE_TICKS   = 200,
  parameter int SETTLE_TICKS = 50
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  output logic          acc_ready,
  input  logic          acc_done,
  input  logic [NB-1:0] bank_present,
  output logic [NB-1:0] bank_rst_req,
  input  logic [NB-1:0] bank_rst_done,
  input  logic [NB-1:0] bank_rst_fail,
  output logic          rail_en,
  output logic          pin_func,
  output logic          idle_pulse,
  output logic          fatal
);
  localparam int SETTLE_CYC = SETTLE_TICKS * TICK_DIV;
  localparam int SW = $clog2(SETTLE_CYC + 1);
  localparam logic [SW-1:0] SLAST = SW'(SETTLE_CYC - 1);

  pm_state_e     state_q, state_d;
  logic [SW-1:0] settle_q;
  logic          tick, expire, touch, enter_on, start_rst;
  logic          all_clear, any_fail;

  pm_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  pm_idle_mon #(.CHECK_TICKS(CHECK_TICKS), .IDLE_TICKS(IDLE_TICKS)) u_idle (
    .clk(clk), .rst_n(rst_n), .tick(tick), .touch(touch), .expire(expire)
  );

  pm_bank_rst #(.NB(NB)) u_banks (
    .clk(clk), .rst_n(rst_n), .start(start_rst), .present(bank_present),
    .done(bank_rst_done), .fail(bank_rst_fail), .req(bank_rst_req),
    .all_clear(all_clear), .any_fail(any_fail)
  );

  assign start_rst = (state_q == PM_SETTLE) && (settle_q == SLAST);
  assign enter_on  = (state_q == PM_BANKRST) && all_clear && !any_fail;
  assign touch     = (acc_valid && acc_ready) || acc_done || enter_on;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_OFF:     if (acc_valid) state_d = PM_SETTLE;
      PM_SETTLE:  if (start_rst) state_d = PM_BANKRST;
      PM_BANKRST: if (all_clear) state_d = any_fail ? PM_FAULT : PM_ON;
      PM_ON:      if (expire) state_d = PM_NOTIFY;
      PM_NOTIFY:  state_d = PM_OFF;
      PM_FAULT:   state_d = PM_FAULT;
      default:    state_d = PM_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_OFF;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     settle_q <= '0;
    else if (state_q != PM_SETTLE)  settle_q <= '0;
    else if (settle_q != SLAST)     settle_q <= settle_q + 1'b1;
  end

  assign rail_en    = (state_q != PM_OFF);
  assign pin_func   = (state_q != PM_OFF);
  assign acc_ready  = (state_q == PM_ON);
  assign idle_pulse = (state_q == PM_NOTIFY);
  assign fatal      = (state_q == PM_FAULT);

  assert_notice_before_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rail_en) |-> $past(idle_pulse));
  assert_notice_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    idle_pulse |=> (!idle_pulse && !rail_en && !pin_func));
  assert_ready_powered_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ready |-> (rail_en && pin_func && !fatal));
  assert_fault_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> (fatal && !acc_ready));
  assert_no_req_at_power_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rail_en) |-> (bank_rst_req == '0));
  assert_off_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rail_en |-> (!idle_pulse && !acc_ready && bank_rst_req == '0));
endmodule

// File: tb/tb_flash_pwr_mgr.sv
module tb_flash_pwr_mgr;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int TD = 4;
  localparam int CHK = 10;
  localparam int IDL = 20;
  localparam int STL = 5;
  localparam int SCYC = STL * TD;
  localparam int NVEC = 6;
  // {present, fail pulses, response delay}
  localparam logic [11:0] VEC [0:NVEC-1] = '{
    {4'b1111, 4'b0000, 4'd2},
    {4'b0101, 4'b0000, 4'd0},
    {4'b0000, 4'b0000, 4'd1},
    {4'b1011, 4'b0010, 4'd3},
    {4'b0110, 4'b1001, 4'd1},
    {4'b1111, 4'b1111, 4'd0}
  };

  logic clk = 0, rst_n = 0;
  logic acc_valid = 0, acc_done = 0;
  logic [NB-1:0] bank_present = '0, bank_rst_done = '0, bank_rst_fail = '0;
  logic acc_ready, rail_en, pin_func, idle_pulse, fatal;
  logic [NB-1:0] bank_rst_req;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_pwr_mgr #(.NB(NB), .TICK_DIV(TD), .CHECK_TICKS(CHK),
                  .IDLE_TICKS(IDL), .SETTLE_TICKS(STL)) dut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_ready(acc_ready),
    .acc_done(acc_done), .bank_present(bank_present), .bank_rst_req(bank_rst_req),
    .bank_rst_done(bank_rst_done), .bank_rst_fail(bank_rst_fail),
    .rail_en(rail_en), .pin_func(pin_func), .idle_pulse(idle_pulse), .fatal(fatal)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    acc_valid = 0; acc_done = 0; bank_rst_done = '0; bank_rst_fail = '0;
    rst_n = 0; step(); step(); rst_n = 1; step();
  endtask

  task automatic run_vec(input logic [3:0] pres, input logic [3:0] fmask,
                         input int dly);
    bit exp_fatal;
    exp_fatal = |(pres & fmask);
    do_reset();
    bank_present = pres;
    acc_valid = 1;
    step();
    chk(rail_en && pin_func, "R2 rail+pins on", {rail_en, pin_func}, 3);
    chk(!acc_ready, "R2 stall during power-up", acc_ready, 0);
    for (int k = 1; k < SCYC; k++) step();
    chk(bank_rst_req == 0, "R3 no req before settle", bank_rst_req, 0);
    step();
    chk(bank_rst_req == pres, "R4 req equals populated", bank_rst_req, pres);
    for (int k = 0; k < dly; k++) begin
      step();
      chk(bank_rst_req == pres, "R4 req held", bank_rst_req, pres);
    end
    bank_rst_done = pres & ~fmask;
    bank_rst_fail = fmask;
    step();
    bank_rst_done = '0; bank_rst_fail = '0;
    chk(bank_rst_req == 0, "R4 req cleared", bank_rst_req, 0);
    step();
    if (exp_fatal) begin
      chk(fatal && !acc_ready, "R6 fault", {fatal, acc_ready}, 2);
      for (int k = 0; k < 60; k++) step();
      chk(fatal && !acc_ready && rail_en, "R6 fault sticky", {fatal, acc_ready}, 2);
    end else begin
      chk(acc_ready && !fatal, "R5 grant", {acc_ready, fatal}, 2);
      step();
      acc_valid = 0;
      chk(rail_en, "R5 still powered", rail_en, 1);
    end
  endtask

  task automatic power_up_ok();
    int guard;
    do_reset();
    bank_present = 4'b1111;
    acc_valid = 1;
    guard = 0;
    while (bank_rst_req == 0 && guard < 100) begin step(); guard++; end
    bank_rst_done = bank_rst_req;
    step();
    bank_rst_done = '0;
    guard = 0;
    while (!acc_ready && guard < 10) begin step(); guard++; end
    step();
    acc_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, pulses, first_pulse;
    do_reset();
    chk(!rail_en && !pin_func && !acc_ready && !idle_pulse && !fatal && bank_rst_req == 0,
        "R1 reset state", {rail_en, pin_func, acc_ready, idle_pulse, fatal}, 0);

    for (int v = 0; v < NVEC; v++)
      run_vec(VEC[v][11:8], VEC[v][7:4], int'(VEC[v][3:0]));

    // R8 / R9: idle shutdown window and notice
    power_up_ok();
    n = 0; pulses = 0; first_pulse = -1;
    while (rail_en && n < 300) begin
      step(); n++;
      if (idle_pulse) begin pulses++; if (first_pulse < 0) first_pulse = n; end
    end
    chk(n > IDL * TD, "R8 not before idle limit", n, IDL * TD + 1);
    chk(n <= (IDL + CHK + 1) * TD + 3, "R8 shutdown in window", n, (IDL + CHK + 1) * TD + 3);
    chk(pulses == 1, "R9 single notice", pulses, 1);
    chk(first_pulse == n - 1, "R9 notice just before off", first_pulse, n - 1);
    chk(!pin_func, "R9 pins to output-low", pin_func, 0);

    // R10: idle checks while unpowered do nothing
    pulses = 0; n = 0;
    for (int k = 0; k < 200; k++) begin
      step();
      if (idle_pulse) pulses++;
      if (rail_en || pin_func) n++;
    end
    chk(pulses == 0 && n == 0, "R10 quiet when off", pulses + n, 0);

    // R7: completion strobes keep the rail up
    power_up_ok();
    n = 0;
    for (int r = 0; r < 5; r++) begin
      for (int k = 0; k < 60; k++) begin step(); if (!rail_en || idle_pulse) n++; end
      acc_done = 1; step(); acc_done = 0;
    end
    chk(n == 0, "R7 done strobe refreshes activity", n, 0);

    // R7 / R2: power-up completion counts as activity, then the re-access after shutdown
    n = 0;
    while (rail_en && n < 300) begin step(); n++; end
    chk(!rail_en && n > IDL * TD, "R7 shutdown after last strobe", n, IDL * TD + 1);
    acc_valid = 1; step();
    chk(rail_en && !acc_ready, "R2 re-power stalls", {rail_en, acc_ready}, 2);
    acc_valid = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule